// File: doc/BRIEF.md
# Packed Byte-Per-Pin GPIO Configuration Registers

This block holds the configuration of a parameterised number of general-purpose pins behind a Wishbone slave port. Every pin owns one 8-bit configuration byte. The byte sets the output level, output enable, input enable, pull-up and pull-down enables and a 3-bit bank number. The bytes are packed side by side into bus words. A 32-bit bus therefore carries four pins per addressed row, and a 64-bit bus carries eight. Byte selects pick the pins inside a row that a transfer touches. Software keeps its own shadow copy of the pin settings, because unselected pins are neither written nor reported.

The block drives the stored fields straight out to the pad ring. It takes the live pad input back so that reads can report it. The bit that sets the output level is shared with the input state. On a pin whose output enable is set, reads return the stored drive level. On any other pin, reads return the live pad input.

Bus handshakes go through a two-state machine. IDLE waits for `cyc` and `stb` together. That request event ("fire") performs the write or captures the read word, and moves to ACK. ACK drives `ack` for exactly one cycle and always returns to IDLE. The only transitions are IDLE→ACK on fire, IDLE→IDLE otherwise, and ACK→IDLE unconditionally.

Top module: `gpio_cfg_regs`

## Requirements
- R1: Each configuration byte has this layout: output enable at bit 0, input enable at bit 1, pull-up at bit 2, pull-down at bit 3, output level / input state at bit 4, and bank number at bits 7:5. The per-pin outputs `pin_oe`, `pin_ie`, `pin_puen`, `pin_pden`, `pin_o` and `pin_bank[3p+:3]` show the stored fields of pin p.
- R2: There are LANES = DATA_W/8 pins per row. Lane l of row address a maps to pin a*LANES+l. Consecutive rows sit at consecutive addresses.
- R3: An acknowledged write stores byte lane l of `wb_dat_i` (bits 8l+7:8l) into the mapped pin when `wb_sel_i[l]` is 1. Pins on unselected lanes keep their value.
- R4: An acknowledged read returns the readback byte of each selected lane in that lane. Unselected lanes read as zero.
- R5: Readback bit 4 is the stored output level when bit 0 (output enable) is 1, and the live `pad_in_i` bit when it is 0. Writing bit 4 while output enable is 0 does not change what reads return.
- R6: `wb_ack_o` rises in the cycle after a clock edge where `cyc` and `stb` are both high and the machine is IDLE. It stays high for exactly one cycle. `cyc` without `stb` produces no ack.
- R7: Lanes that map to a pin index at or above NUM_PINS, including whole rows past the last pin, read as zero and ignore writes.
- R8: Synchronous reset clears every configuration byte to zero, giving an input pin in bank 0 with all enables off, and clears `wb_ack_o`.
- R9: `wb_dat_o` is zero while a write is being acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Row address |
| wb_sel_i | input | DATA_W/8 | Byte-lane selects, one per pin of the row |
| wb_dat_i | input | DATA_W | Write data, one configuration byte per lane |
| wb_dat_o | output | DATA_W | Read data, valid while ack is high |
| wb_ack_o | output | 1 | One-cycle transfer acknowledge |
| pad_in_i | input | NUM_PINS | Live pad input levels |
| pin_o | output | NUM_PINS | Output level per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_ie | output | NUM_PINS | Input enable per pin |
| pin_puen | output | NUM_PINS | Pull-up enable per pin |
| pin_pden | output | NUM_PINS | Pull-down enable per pin |
| pin_bank | output | 3*NUM_PINS | Bank number per pin, pin p at bits 3p+2:3p |

## Verification
The bench is built with 14 pins on a 32-bit bus, so the last row has two live lanes and two dead ones. The dead lanes, and every row past the last, are written with all ones and then read back. A design that decoded only the row address would show nonzero bytes there. The bench writes bit 4 high on input pins while the pads are low, then raises the pads. A design that returned the stored bit regardless of direction would miss the pad change, while one that always returned the pad would break the output pins next to them. Partial byte selects on both reads and writes expose a design that writes whole rows or leaks unselected bytes. Holding `stb` over two edges shows whether ack is a true one-cycle pulse.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    // Configuration byte, most significant field first.
    typedef struct packed {
        logic [2:0] bank;   // bits 7:5
        logic       io;     // bit 4: drive level / input state
        logic       pden;   // bit 3
        logic       puen;   // bit 2
        logic       ie;     // bit 1
        logic       oe;     // bit 0
    } pin_cfg_t;

    localparam int CFG_W  = 8;
    localparam int BANK_W = 3;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_t;

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm (
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    output logic fire,
    output logic ack
);
    import gpio_cfg_pkg::*;

    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (cyc && stb) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        fire = 1'b0;
        ack  = 1'b0;
        unique case (state_q)
            BUS_IDLE: fire = cyc && stb;
            BUS_ACK:  ack  = 1'b1;
            default:  ;
        endcase
    end

    // R6: the acknowledge is a single-cycle pulse
    a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R6: a request seen in IDLE is acknowledged on the next cycle
    a_r6_ack_follows: assert property (@(posedge clk) disable iff (rst)
        (!ack && cyc && stb) |=> ack);

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       pad_in,
    output logic [7:0] cfg_byte,
    output logic [7:0] rd_byte
);
    import gpio_cfg_pkg::*;

    pin_cfg_t cfg_q;
    pin_cfg_t rd_view;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= pin_cfg_t'(wr_byte);
    end

    // The shared level bit reports the pad unless the pin drives.
    always_comb begin
        rd_view    = cfg_q;
        rd_view.io = cfg_q.oe ? cfg_q.io : pad_in;
    end

    assign cfg_byte = cfg_q;
    assign rd_byte  = rd_view;

    // R3: a written byte lands in the register
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_byte == $past(wr_byte)));

    // R3: without a write the byte holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_byte));

endmodule

// File: rtl/gpio_row_mux.sv
module gpio_row_mux #(
    parameter int NUM_PINS = 14,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    localparam int LANES   = DATA_W / 8
) (
    input  logic [ADDR_W-1:0]     row,
    input  logic [LANES-1:0]      sel,
    input  logic [NUM_PINS*8-1:0] rd_bytes,
    output logic [DATA_W-1:0]     word
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        int unsigned pin_idx;
        always_comb begin
            pin_idx = int'(row) * LANES + l;
            if (sel[l] && pin_idx < NUM_PINS)
                word[l*8 +: 8] = rd_bytes[pin_idx*8 +: 8];
            else
                word[l*8 +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
    parameter int NUM_PINS = 14,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    localparam int LANES   = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wb_cyc_i,
    input  logic                  wb_stb_i,
    input  logic                  wb_we_i,
    input  logic [ADDR_W-1:0]     wb_adr_i,
    input  logic [LANES-1:0]      wb_sel_i,
    input  logic [DATA_W-1:0]     wb_dat_i,
    output logic [DATA_W-1:0]     wb_dat_o,
    output logic                  wb_ack_o,
    input  logic [NUM_PINS-1:0]   pad_in_i,
    output logic [NUM_PINS-1:0]   pin_o,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_ie,
    output logic [NUM_PINS-1:0]   pin_puen,
    output logic [NUM_PINS-1:0]   pin_pden,
    output logic [3*NUM_PINS-1:0] pin_bank
);
    import gpio_cfg_pkg::*;

    logic                  fire;
    logic [NUM_PINS*8-1:0] cfg_flat;
    logic [NUM_PINS*8-1:0] rd_flat;
    logic [NUM_PINS-1:0]   wr_en;
    logic [DATA_W-1:0]     rd_word;
    logic [DATA_W-1:0]     dat_q;

    gpio_bus_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .cyc  (wb_cyc_i),
        .stb  (wb_stb_i),
        .fire (fire),
        .ack  (wb_ack_o)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int ROW  = p / LANES;
        localparam int LANE = p % LANES;
        pin_cfg_t cfg_v;

        assign wr_en[p] = fire && wb_we_i && wb_sel_i[LANE]
                          && (int'(wb_adr_i) == ROW);

        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en[p]),
            .wr_byte  (wb_dat_i[LANE*8 +: 8]),
            .pad_in   (pad_in_i[p]),
            .cfg_byte (cfg_flat[p*8 +: 8]),
            .rd_byte  (rd_flat[p*8 +: 8])
        );

        assign cfg_v           = pin_cfg_t'(cfg_flat[p*8 +: 8]);
        assign pin_o[p]        = cfg_v.io;
        assign pin_oe[p]       = cfg_v.oe;
        assign pin_ie[p]       = cfg_v.ie;
        assign pin_puen[p]     = cfg_v.puen;
        assign pin_pden[p]     = cfg_v.pden;
        assign pin_bank[p*3 +: 3] = cfg_v.bank;
    end

    gpio_row_mux #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_mux (
        .row      (wb_adr_i),
        .sel      (wb_sel_i),
        .rd_bytes (rd_flat),
        .word     (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst)       dat_q <= '0;
        else if (fire) dat_q <= wb_we_i ? '0 : rd_word;
    end

    assign wb_dat_o = dat_q;

    // R9: a write acknowledge carries no data
    a_r9_write_zero: assert property (@(posedge clk) disable iff (rst)
        (fire && wb_we_i) |=> (wb_ack_o && wb_dat_o == '0));

    // R3: a pin is only written on a single request edge at a time
    a_r3_write_onehot_row: assert property (@(posedge clk) disable iff (rst)
        !fire |-> (wr_en == '0));

endmodule

// File: tb/gpio_cfg_regs_tb.sv
module gpio_cfg_regs_tb;

    localparam int NUM_PINS = 14;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int LANES    = DATA_W / 8;
    localparam int NVEC     = 14;

    // {we, adr, sel, data, expected dat_o at ack}
    localparam logic [71:0] VEC [0:NVEC-1] = '{
        {1'b1, 3'd0, 4'hF, 32'h1DE51131, 32'h00000000},
        {1'b0, 3'd0, 4'hF, 32'h00000000, 32'h1DE51131},
        {1'b0, 3'd0, 4'h5, 32'h00000000, 32'h00E50031},
        {1'b1, 3'd1, 4'h6, 32'hFF1234FF, 32'h00000000},
        {1'b0, 3'd1, 4'hF, 32'h00000000, 32'h00022400},
        {1'b1, 3'd0, 4'h8, 32'h42000000, 32'h00000000},
        {1'b0, 3'd0, 4'hF, 32'h00000000, 32'h42E51131},
        {1'b1, 3'd3, 4'hF, 32'hA1A1A1A1, 32'h00000000},
        {1'b0, 3'd3, 4'hF, 32'h00000000, 32'h0000A1A1},
        {1'b1, 3'd5, 4'hF, 32'hFFFFFFFF, 32'h00000000},
        {1'b0, 3'd5, 4'hF, 32'h00000000, 32'h00000000},
        {1'b0, 3'd2, 4'hF, 32'h00000000, 32'h00000000},
        {1'b1, 3'd2, 4'h3, 32'h55552111, 32'h00000000},
        {1'b0, 3'd2, 4'hF, 32'h00000000, 32'h00002111}
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [ADDR_W-1:0]     adr = '0;
    logic [LANES-1:0]      sel = '0;
    logic [DATA_W-1:0]     dat_i = '0;
    logic [DATA_W-1:0]     dat_o;
    logic                  ack;
    logic [NUM_PINS-1:0]   pad = '0;
    logic [NUM_PINS-1:0]   p_o, p_oe, p_ie, p_pu, p_pd;
    logic [3*NUM_PINS-1:0] p_bank;

    int n_vec = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_sel_i(sel), .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack),
        .pad_in_i(pad), .pin_o(p_o), .pin_oe(p_oe), .pin_ie(p_ie),
        .pin_puen(p_pu), .pin_pden(p_pd), .pin_bank(p_bank)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xact(input logic w, input logic [ADDR_W-1:0] a, input logic [LANES-1:0] s,
                        input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] rd);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; dat_i = d;
        @(negedge clk);
        check("R6 ack high", 64'(ack), 64'd1);
        rd = dat_o;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
        check("R6 ack one cycle", 64'(ack), 64'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 20000 && !done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check("R8 ack after reset", 64'(ack), 64'd0);
        check("R8 oe after reset", 64'(p_oe), 64'd0);
        check("R8 bank after reset", 64'(p_bank), 64'd0);
        xact(1'b0, 3'd0, 4'hF, '0, rd);
        check("R8 row0 after reset", 64'(rd), 64'd0);

        // Vector table: R2 R3 R4 R5 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            xact(VEC[i][71], VEC[i][70:68], VEC[i][67:64], VEC[i][63:32], rd);
            check(VEC[i][71] ? "R9 write data zero" : "R2/R3/R4/R7 readback",
                  64'(rd), 64'(VEC[i][31:0]));
        end

        // R1: field outputs
        check("R1 pin0 oe/o", {62'd0, p_oe[0], p_o[0]}, 64'd3);
        check("R1 pin0 bank", 64'(p_bank[0 +: 3]), 64'd1);
        check("R1 pin2 puen/o", {62'd0, p_pu[2], p_o[2]}, 64'd2);
        check("R1 pin2 bank", 64'(p_bank[6 +: 3]), 64'd7);
        check("R1 pin3 oe/ie/pden", {61'd0, p_oe[3], p_ie[3], p_pd[3]}, 64'd2);
        check("R1 pin3 bank", 64'(p_bank[9 +: 3]), 64'd2);
        check("R1 pin12 oe/bank", {60'd0, p_oe[12], p_bank[36 +: 3]}, 64'hD);

        // R5: input pins report the pad, driving pins report stored level
        @(negedge clk);
        pad = 14'h006C; // pins 2,3,5,6 high
        xact(1'b0, 3'd1, 4'hF, '0, rd);
        check("R5 input pins follow pad", 64'(rd), 64'h00123400);
        xact(1'b0, 3'd0, 4'hF, '0, rd);
        check("R5 mixed row with pad high", 64'(rd), 64'h52E51131);

        // R6: cyc without stb gives no ack
        @(negedge clk);
        cyc = 1'b1; stb = 1'b0;
        @(negedge clk);
        check("R6 no ack without stb", 64'(ack), 64'd0);
        @(negedge clk);
        check("R6 no ack without stb 2", 64'(ack), 64'd0);
        // R6: held strobe still yields a one-cycle pulse
        stb = 1'b1; we = 1'b0; adr = 3'd0; sel = 4'hF;
        @(negedge clk);
        check("R6 held stb first ack", 64'(ack), 64'd1);
        @(negedge clk);
        check("R6 held stb gap", 64'(ack), 64'd0);
        cyc = 1'b0; stb = 1'b0;
        repeat (2) @(negedge clk);

        // R8: reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pad = '0;
        xact(1'b0, 3'd0, 4'hF, '0, rd);
        check("R8 row0 after second reset", 64'(rd), 64'd0);
        check("R8 outputs after second reset", 64'(p_oe | p_ie | p_o), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule